// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between the register file and a 32-bit, word-addressed data memory port. For every request it adds a sign-extended 16-bit displacement to a base register value to form the byte address. It then checks that the address is naturally aligned for the access width and, if it is, issues one memory operation. An access that fails the alignment check raises a fault flag in the same cycle and reaches memory not at all.

On stores the unit places the narrow datum in every lane of the write word and marks the lanes to be written with byte enables. On loads the memory returns its word in the request cycle. The unit registers that word together with the lane offset and the extension mode. One cycle after the request it delivers the selected byte or halfword, sign-extended or zero-extended to 32 bits. Lanes are numbered big-endian: byte offset 0 is data bits 31:24.

Top module: `lsx_unit`

## Requirements
- R1: The byte address is `base` plus `disp` sign-extended to 32 bits (modulo 2^32), and `mem_addr` carries its bits 31:2 whenever `mem_valid` is high.
- R2: A halfword request (`req_size` = 01) whose address has bit 0 set drives `misalign` high and keeps `mem_valid` low in that cycle.
- R3: A word request (`req_size` = 10) whose address bits 1:0 are not both zero drives `misalign` high and keeps `mem_valid` low in that cycle.
- R4: A byte request (`req_size` = 00) never faults; it is issued at every byte offset.
- R5: `mem_be` marks the lanes accessed, with bit 3 standing for data bits 31:24. A byte at offset k gives 4'b1000 shifted right by k. A halfword gives 4'b1100 at offset 0 and 4'b0011 at offset 2. A word gives 4'b1111. When no operation is issued, `mem_be` is zero.
- R6: `mem_wdata` holds the low byte of `store_data` repeated four times for byte stores, the low halfword repeated twice for halfword stores, and `store_data` unchanged for word stores.
- R7: A load returns the lane that sits at its byte offset in big-endian order: offset 0 is bits 31:24, offset 3 is bits 7:0, halfword offset 0 is bits 31:16 and offset 2 is bits 15:0.
- R8: Narrow loads with `req_unsigned` = 1 are zero-extended and otherwise sign-extended; word loads return the memory word unchanged regardless of `req_unsigned`.
- R9: `load_valid` is high in exactly the cycle after an issued load, and `load_data` holds the result in that cycle. Stores, faulting requests and idle cycles give no `load_valid`.
- R10: After reset `load_valid` is low and `load_data` is zero.
- R11: `req_size` code 11 behaves as a word access, including the alignment check.
- R12: `mem_we` is high only for an issued store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend narrow load result |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Register value to store |
| mem_valid | output | 1 | Memory operation issued |
| mem_we | output | 1 | Issued operation is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read word, valid in the request cycle |
| misalign | output | 1 | Alignment fault for the current request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
Two functions can fall in the same cycle: a load's registered result is returned while the next request is being checked and issued. The bench provokes this by issuing a signed byte load and, in the following cycle, a misaligned word store. The bench then judges that cycle on both counts. The loaded byte must appear correctly extended on `load_data`. The store must raise `misalign` with no enables and no write. In a second pairing, a load followed directly by an aligned store must leave the returned value unaffected by the store's data.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int WADDR_W = DATA_W - OFF_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } acc_size_e;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        acc_size_e        sz;
        logic             zext;
    } ld_meta_t;

    // Code 11 is folded onto the word width.
    function automatic acc_size_e decode_size(input logic [1:0] code);
        case (code)
            2'b00:   decode_size = SZ_BYTE;
            2'b01:   decode_size = SZ_HALF;
            default: decode_size = SZ_WORD;
        endcase
    endfunction

    function automatic logic is_misaligned(input acc_size_e sz, input logic [OFF_W-1:0] off);
        case (sz)
            SZ_HALF: is_misaligned = off[0];
            SZ_WORD: is_misaligned = |off;
            default: is_misaligned = 1'b0;
        endcase
    endfunction

    // Big-endian lane mask: bit LANES-1 is the most significant byte.
    function automatic logic [LANES-1:0] lane_mask(input acc_size_e sz, input logic [OFF_W-1:0] off);
        logic [LANES-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            case (sz)
                SZ_BYTE: m[LANES-1-i] = (i == int'(off));
                SZ_HALF: m[LANES-1-i] = ((i >> 1) == (int'(off) >> 1));
                default: m[LANES-1-i] = 1'b1;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/lsx_addr_gen.sv
module lsx_addr_gen
    import lsx_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  acc_size_e         sz,
    output logic [DATA_W-1:0] ea,
    output logic              bad_align
);
    localparam int EXT_W = DATA_W - DISP_W;

    logic [DATA_W-1:0] disp_sx;

    always_comb begin
        disp_sx   = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea        = base + disp_sx;
        bad_align = is_misaligned(sz, ea[OFF_W-1:0]);
    end
endmodule

// File: rtl/lsx_store_steer.sv
module lsx_store_steer
    import lsx_pkg::*;
(
    input  acc_size_e         sz,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        be = lane_mask(sz, off);
        case (sz)
            SZ_BYTE: wdata = {LANES{src[7:0]}};
            SZ_HALF: wdata = {2{src[HALF_W-1:0]}};
            default: wdata = src;
        endcase
    end
endmodule

// File: rtl/lsx_load_extract.sv
module lsx_load_extract
    import lsx_pkg::*;
(
    input  ld_meta_t          meta,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W = DATA_W / 2;

    logic [7:0]        byte_lanes [LANES];
    logic [HALF_W-1:0] half_lanes [2];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_byte
            assign byte_lanes[g] = word[DATA_W-1-8*g -: 8];
        end
        for (g = 0; g < 2; g++) begin : g_half
            assign half_lanes[g] = word[DATA_W-1-HALF_W*g -: HALF_W];
        end
    endgenerate

    logic [7:0]        sel_b;
    logic [HALF_W-1:0] sel_h;

    always_comb begin
        sel_b = byte_lanes[meta.off];
        sel_h = half_lanes[meta.off[OFF_W-1]];
        case (meta.sz)
            SZ_BYTE: result = {{(DATA_W-8){sel_b[7] & ~meta.zext}}, sel_b};
            SZ_HALF: result = {{(DATA_W-HALF_W){sel_h[HALF_W-1] & ~meta.zext}}, sel_h};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsx_unit.sv
module lsx_unit
    import lsx_pkg::*;
#(
    parameter int DISP_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_is_store,
    input  logic [1:0]         req_size,
    input  logic               req_unsigned,
    input  logic [DATA_W-1:0]  base,
    input  logic [DISP_W-1:0]  disp,
    input  logic [DATA_W-1:0]  store_data,
    output logic               mem_valid,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               misalign,
    output logic               load_valid,
    output logic [DATA_W-1:0]  load_data
);
    acc_size_e         sz;
    logic [DATA_W-1:0] ea;
    logic              bad_align;
    logic [LANES-1:0]  steer_be;
    logic              issue_load;

    ld_meta_t          meta_q;
    logic [DATA_W-1:0] word_q;

    assign sz = decode_size(req_size);

    lsx_addr_gen #(.DISP_W(DISP_W)) u_addr (
        .base      (base),
        .disp      (disp),
        .sz        (sz),
        .ea        (ea),
        .bad_align (bad_align)
    );

    lsx_store_steer u_steer (
        .sz    (sz),
        .off   (ea[OFF_W-1:0]),
        .src   (store_data),
        .be    (steer_be),
        .wdata (mem_wdata)
    );

    always_comb begin
        misalign   = req_valid & bad_align;
        mem_valid  = req_valid & ~bad_align;
        mem_we     = mem_valid & req_is_store;
        issue_load = mem_valid & ~req_is_store;
        mem_addr   = ea[DATA_W-1:OFF_W];
        mem_be     = mem_valid ? steer_be : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_valid <= 1'b0;
            meta_q     <= '0;
            word_q     <= '0;
        end else begin
            load_valid <= issue_load;
            if (issue_load) begin
                meta_q <= '{off: ea[OFF_W-1:0], sz: sz, zext: req_unsigned};
                word_q <= mem_rdata;
            end
        end
    end

    lsx_load_extract u_extract (
        .meta   (meta_q),
        .word   (word_q),
        .result (load_data)
    );
endmodule

// File: rtl/lsx_unit_chk.sv
module lsx_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_is_store,
    input logic [1:0] req_size,
    input logic       mem_valid,
    input logic       mem_we,
    input logic [3:0] mem_be,
    input logic       misalign,
    input logic       load_valid
);
    // R2
    fault_blocks_issue_chk: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (!mem_valid && mem_be == 4'b0000));

    // R4
    byte_never_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b00) |-> !misalign);

    // R5
    be_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

    // R9
    load_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        load_valid |-> $past(mem_valid && !mem_we));

    // R9
    no_result_after_store_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !load_valid);

    // R11
    code3_full_word_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && req_size == 2'b11) |-> mem_be == 4'b1111);

    // R12
    write_only_for_store_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (req_valid && req_is_store));
endmodule

bind lsx_unit lsx_unit_chk u_lsx_unit_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .req_size     (req_size),
    .mem_valid    (mem_valid),
    .mem_we       (mem_we),
    .mem_be       (mem_be),
    .misalign     (misalign),
    .load_valid   (load_valid)
);

// File: tb/test_lsx_unit.sv
`timescale 1ns/1ps
module test_lsx_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_store, req_unsigned;
    logic [1:0]  req_size;
    logic [31:0] base, store_data, mem_rdata;
    logic [15:0] disp;
    logic        mem_valid, mem_we, misalign, load_valid;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, load_data;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lsx_unit i_lsx_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .base(base), .disp(disp),
        .store_data(store_data), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .misalign(misalign), .load_valid(load_valid),
        .load_data(load_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference values
    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'b00) return 4'b1000 >> off;
        if (sz == 2'b01) return (off == 2'd0) ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] ref_load(input logic [1:0] sz, input logic uns,
                                             input logic [1:0] off, input logic [31:0] w);
        logic [31:0] s;
        s = w << (8 * off);
        if (sz == 2'b00) return uns ? {24'd0, s[31:24]} : {{24{s[31]}}, s[31:24]};
        if (sz == 2'b01) return uns ? {16'd0, s[31:16]} : {{16{s[31]}}, s[31:16]};
        return w;
    endfunction

    task automatic idle();
        req_valid = 1'b0; req_is_store = 1'b0; req_size = 2'b00; req_unsigned = 1'b0;
        base = '0; disp = '0; store_data = '0; mem_rdata = '0;
    endtask

    // Drive a request just after a falling edge; combinational outputs settle 1 ns later.
    task automatic drive(input logic st, input logic [1:0] sz, input logic uns,
                         input logic [31:0] b, input logic [15:0] d,
                         input logic [31:0] sd, input logic [31:0] rd);
        req_valid = 1'b1; req_is_store = st; req_size = sz; req_unsigned = uns;
        base = b; disp = d; store_data = sd; mem_rdata = rd;
        #1;
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 load_valid after reset", {31'd0, load_valid}, 32'd0);
        chk("R10 load_data after reset", load_data, 32'd0);
    endtask

    task automatic t_address();
        drive(1'b0, 2'b10, 1'b0, 32'h0000_1000, 16'hFFFC, 32'd0, 32'hCAFE_F00D);
        chk("R1 negative disp mem_addr", {2'b0, mem_addr}, 32'h0000_0FFC >> 2);
        chk("R1 negative disp issued", {31'd0, mem_valid}, 32'd1);
        next_cycle();
        chk("R9 word load valid", {31'd0, load_valid}, 32'd1);
        chk("R8 word load unchanged", load_data, 32'hCAFE_F00D);
        drive(1'b1, 2'b10, 1'b0, 32'hFFFF_FFF0, 16'h7FF0, 32'h1, 32'd0);
        chk("R1 wrap positive disp", {2'b0, mem_addr}, 32'h0000_7FE0 >> 2);
        chk("R12 store writes", {31'd0, mem_we}, 32'd1);
        next_cycle();
        chk("R9 no result after store", {31'd0, load_valid}, 32'd0);
        idle();
        next_cycle();
    endtask

    task automatic t_store_lanes();
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 4; off++) begin
                if ((sz == 1 && off[0]) || (sz == 2 && off != 0)) continue;
                drive(1'b1, 2'(sz), 1'b0, 32'h0000_2000 + 32'(off), 16'h0, 32'hA1B2_C3D4, 32'd0);
                chk($sformatf("R5 be sz%0d off%0d", sz, off), {28'd0, mem_be}, {28'd0, ref_be(2'(sz), 2'(off))});
                chk($sformatf("R6 wdata sz%0d off%0d", sz, off), mem_wdata,
                    sz == 0 ? 32'hD4D4_D4D4 : sz == 1 ? 32'hC3D4_C3D4 : 32'hA1B2_C3D4);
                next_cycle();
            end
        end
        idle();
        #1;
        chk("R5 idle be zero", {28'd0, mem_be}, 32'd0);
        chk("R12 idle no write", {31'd0, mem_we}, 32'd0);
        next_cycle();
    endtask

    task automatic t_load_lanes();
        logic [31:0] w;
        w = 32'h807F_12F0;
        for (int sz = 0; sz < 2; sz++) begin
            for (int off = 0; off < 4; off++) begin
                for (int u = 0; u < 2; u++) begin
                    if (sz == 1 && off[0]) continue;
                    drive(1'b0, 2'(sz), u[0], 32'h0000_3000, 16'(off), 32'd0, w);
                    next_cycle();
                    idle();
                    chk($sformatf("R7 R8 load sz%0d off%0d uns%0d", sz, off, u), load_data,
                        ref_load(2'(sz), u[0], 2'(off), w));
                end
            end
        end
        drive(1'b0, 2'b10, 1'b1, 32'h0000_3000, 16'h0, 32'd0, 32'h8000_0001);
        next_cycle();
        idle();
        chk("R8 word ignores unsigned", load_data, 32'h8000_0001);
        next_cycle();
    endtask

    task automatic t_faults();
        drive(1'b0, 2'b01, 1'b0, 32'h0000_4001, 16'h0, 32'd0, 32'hFFFF_FFFF);
        chk("R2 half odd faults", {31'd0, misalign}, 32'd1);
        chk("R2 half odd not issued", {31'd0, mem_valid}, 32'd0);
        next_cycle();
        chk("R9 no result after fault", {31'd0, load_valid}, 32'd0);
        drive(1'b1, 2'b10, 1'b0, 32'h0000_4000, 16'h0002, 32'd5, 32'd0);
        chk("R3 word off2 faults", {31'd0, misalign}, 32'd1);
        chk("R3 word off2 no write", {31'd0, mem_we}, 32'd0);
        next_cycle();
        drive(1'b0, 2'b00, 1'b0, 32'h0000_4000, 16'h0003, 32'd0, 32'd0);
        chk("R4 byte off3 no fault", {31'd0, misalign}, 32'd0);
        chk("R4 byte off3 issued", {31'd0, mem_valid}, 32'd1);
        next_cycle();
        drive(1'b0, 2'b11, 1'b0, 32'h0000_4000, 16'h0001, 32'd0, 32'd0);
        chk("R11 code3 off1 faults", {31'd0, misalign}, 32'd1);
        next_cycle();
        drive(1'b0, 2'b11, 1'b0, 32'h0000_4000, 16'h0004, 32'd0, 32'h1234_5678);
        chk("R11 code3 aligned be", {28'd0, mem_be}, 32'hF);
        next_cycle();
        idle();
        chk("R11 code3 full word", load_data, 32'h1234_5678);
        next_cycle();
    endtask

    task automatic t_overlap();
        drive(1'b0, 2'b00, 1'b0, 32'h0000_5000, 16'h0001, 32'd0, 32'h0090_0000);
        next_cycle();
        drive(1'b1, 2'b10, 1'b0, 32'h0000_5000, 16'h0003, 32'h7777_7777, 32'hFFFF_FFFF);
        chk("R9 overlap load valid", {31'd0, load_valid}, 32'd1);
        chk("R8 overlap load sign", load_data, 32'hFFFF_FF90);
        chk("R3 overlap store faults", {31'd0, misalign}, 32'd1);
        chk("R5 overlap no enables", {28'd0, mem_be}, 32'd0);
        next_cycle();
        drive(1'b0, 2'b01, 1'b1, 32'h0000_5000, 16'h0002, 32'd0, 32'h0000_ABCD);
        next_cycle();
        drive(1'b1, 2'b10, 1'b0, 32'h0000_5000, 16'h0, 32'h1111_1111, 32'h2222_2222);
        chk("R7 load beside store", load_data, 32'h0000_ABCD);
        chk("R12 store beside load", {31'd0, mem_we}, 32'd1);
        next_cycle();
        idle();
        chk("R9 store leaves no result", {31'd0, load_valid}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_address();
        t_store_lanes();
        t_load_lanes();
        t_faults();
        t_overlap();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule